// File: doc/BRIEF.md
# Core Mailbox and Signal Notification Unit

This unit carries short 32-bit messages between a single compute core and the other agents on the chip. The core talks to it through channel operations: a read or write request names a channel and is held until the unit acknowledges it, so an operation that cannot complete simply stalls the core. The core can also ask for a count on any channel, which gives the number of words waiting or the number of free slots.

Other agents reach the unit through a memory-mapped port. They push words into a four-deep inbound mailbox, write two signal-notification registers, and drain two single-word outbound mailboxes. When the core posts into the second outbound mailbox, an interrupt line to the host goes up and stays up until the host drains that mailbox. Each signal register can be strapped to replace its contents on every write or to OR each write into what is already there, so several senders can each set their own bit. A core read of a signal register hands back the gathered bits and empties the register.

Top module: `msgu_top`

## Requirements
- R1: After reset the inbound mailbox is empty (count select 0 reads 0), both outbound mailboxes are empty (count selects 3 and 4 read 1), both signal registers are zero (count selects 1 and 2 read 0), and `host_irq` and `inbox_ovf` are low.
- R2: Host writes to address 0 enter the inbound mailbox, which holds four words; a core read on read channel 0 returns them oldest first, count select 0 gives the number waiting, and the read is not acknowledged while the mailbox is empty.
- R3: A host write to address 0 while the inbound mailbox holds four words and no core read completes in that cycle replaces the newest stored word, leaves the count at four, and sets `inbox_ovf`, which then stays high until reset.
- R4: Write channel 0 and write channel 1 each feed a one-word outbound mailbox; a core write is acknowledged only when the target is empty, and count selects 3 and 4 give the free slots (1 or 0) of channels 0 and 1.
- R5: A host read of address 3 or 4 returns the word held in outbound mailbox 0 or 1 combinationally and empties it at the clock edge; a host read of an empty outbound mailbox returns zero.
- R6: `host_irq` goes high the cycle after a core write to write channel 1 is acknowledged and stays high until the cycle after a host read of address 4.
- R7: When `sig_or_mode` bit n is 0, a host write to address 1+n replaces the contents of signal register n.
- R8: When `sig_or_mode` bit n is 1, a host write to address 1+n ORs the written word into signal register n.
- R9: A core read on read channel 1+n is acknowledged only while signal register n is nonzero, returns its value and clears it; count selects 1 and 2 read 1 when the register is nonzero and 0 otherwise.
- R10: When a host signal write and a core read of the same signal register fall in one cycle, the core receives the old value and the register afterwards holds exactly the written word.
- R11: When a host write to address 0 and a core read on read channel 0 fall in one cycle with the inbound mailbox full, the core receives the oldest word, the new word is appended, the count stays four and `inbox_ovf` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_rd_req | input | 1 | Core channel read request, held until acknowledged |
| core_rd_sel | input | 3 | Read channel: 0 inbound, 1 signal 0, 2 signal 1 |
| core_rd_ack | output | 1 | Read completes this cycle |
| core_rd_data | output | DATA_W | Read data, valid with acknowledge |
| core_wr_req | input | 1 | Core channel write request, held until acknowledged |
| core_wr_sel | input | 3 | Write channel: 0 outbound 0, 1 outbound 1 (interrupting) |
| core_wr_data | input | DATA_W | Write data |
| core_wr_ack | output | 1 | Write completes this cycle |
| core_cnt_sel | input | 3 | Count select: 0 inbound, 1-2 signals, 3-4 outbound |
| core_cnt | output | CNT_W | Count of waiting words or free slots |
| host_wr_en | input | 1 | Memory-mapped write strobe |
| host_rd_en | input | 1 | Memory-mapped read strobe |
| host_addr | input | 3 | 0 inbound, 1-2 signals, 3-4 outbound |
| host_wr_data | input | DATA_W | Memory-mapped write data |
| host_rd_data | output | DATA_W | Memory-mapped read data |
| sig_or_mode | input | 2 | Per signal register: 1 ORs writes, 0 replaces |
| host_irq | output | 1 | Outbound mailbox 1 holds a word |
| inbox_ovf | output | 1 | Sticky inbound overflow flag |

## Verification
The main flow is driven as a scripted list of host and core operations that fills and drains the inbound mailbox in order, posts and collects outbound words, and writes both signal registers in each merge mode; comparing two writes of disjoint bit patterns tells replacement apart from OR merging, and reads against empty channels separate blocking from stale data. Directed cases then collide a host write with a core read on a full inbound mailbox and on a signal register, which tells overflow replacement apart from ordinary append and shows which value the core sees. The interrupt is watched across idle cycles to separate a level held until drain from a pulse.

// File: rtl/msgu_pkg.sv
package msgu_pkg;
  localparam int DATA_W = 32;
  localparam int N_OUT  = 2;
  localparam int N_SIG  = 2;
  localparam int SEL_W  = 3;

  // core read channels
  localparam logic [SEL_W-1:0] RCH_INBOX = 3'd0;
  localparam logic [SEL_W-1:0] RCH_SIG0  = 3'd1;
  // core count selects
  localparam logic [SEL_W-1:0] CNT_INBOX = 3'd0;
  localparam logic [SEL_W-1:0] CNT_SIG0  = 3'd1;
  localparam logic [SEL_W-1:0] CNT_OUT0  = 3'd3;
  // host addresses
  localparam logic [SEL_W-1:0] HA_INBOX  = 3'd0;
  localparam logic [SEL_W-1:0] HA_SIG0   = 3'd1;
  localparam logic [SEL_W-1:0] HA_OUT0   = 3'd3;
  // index of the outbound mailbox that raises the interrupt
  localparam int IRQ_OUT = 1;
endpackage

// File: rtl/msgu_inbox.sv
module msgu_inbox #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              ovf
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n, last_ptr;
  logic [CW-1:0] count_n;
  logic          ovf_n;
  logic          full, empty, do_pop, do_push, do_ovw;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
  endfunction

  always_comb begin
    full     = (count == CW'(DEPTH));
    empty    = (count == '0);
    do_pop   = pop && !empty;
    do_ovw   = push && full && !do_pop;
    do_push  = push && !do_ovw;
    last_ptr = ptr_dec(wr_ptr);
    wr_ptr_n = do_push ? ptr_inc(wr_ptr) : wr_ptr;
    rd_ptr_n = do_pop ? ptr_inc(rd_ptr) : rd_ptr;
    count_n  = count + CW'(do_push) - CW'(do_pop);
    ovf_n    = ovf | do_ovw;
    head     = mem[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
      ovf    <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)     mem[wr_ptr]   <= push_data;
    else if (do_ovw) mem[last_ptr] <= push_data;
  end

  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  a_r3_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && count == CW'(DEPTH)) |=> (count == CW'(DEPTH) && ovf));
  a_r11_swap_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && count == CW'(DEPTH)) |=> (count == CW'(DEPTH) && ovf == $past(ovf)));
endmodule

// File: rtl/msgu_outbox.sv
module msgu_outbox #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_n;
  logic [DATA_W-1:0] data_n;
  logic              data_en;

  always_comb begin
    data_en = wr;
    data_n  = wr_data;
    if (wr)                full_n = 1'b1;
    else if (rd && full)   full_n = 1'b0;
    else                   full_n = full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_n;
      if (data_en) data <= data_n;
    end
  end

  a_r4_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !full);
  a_r5_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && full && !wr) |=> !full);
  a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (full && data == $past(wr_data)));
endmodule

// File: rtl/msgu_sig.sv
module msgu_sig #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              or_mode,
  input  logic              clr,
  output logic [DATA_W-1:0] val
);
  logic [DATA_W-1:0] val_n;
  logic              val_en;

  always_comb begin
    val_en = wr || clr;
    if (clr)          val_n = wr ? wr_data : '0;
    else if (or_mode) val_n = val | wr_data;
    else              val_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val <= '0;
    else if (val_en) val <= val_n;
  end

  a_r7_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !or_mode) |=> val == $past(wr_data));
  a_r8_or_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && or_mode && !clr) |=> val == ($past(val) | $past(wr_data)));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr) |=> val == '0);
  a_r10_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && wr) |=> val == $past(wr_data));
endmodule

// File: rtl/msgu_top.sv
module msgu_top
  import msgu_pkg::*;
#(
  parameter int IN_DEPTH = 4,
  localparam int CNT_W = $clog2(IN_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rd_req,
  input  logic [2:0]        core_rd_sel,
  output logic              core_rd_ack,
  output logic [DATA_W-1:0] core_rd_data,
  input  logic              core_wr_req,
  input  logic [2:0]        core_wr_sel,
  input  logic [DATA_W-1:0] core_wr_data,
  output logic              core_wr_ack,
  input  logic [2:0]        core_cnt_sel,
  output logic [CNT_W-1:0]  core_cnt,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [2:0]        host_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic [DATA_W-1:0] host_rd_data,
  input  logic [1:0]        sig_or_mode,
  output logic              host_irq,
  output logic              inbox_ovf
);
  logic              ib_push, ib_pop;
  logic [DATA_W-1:0] ib_head;
  logic [CNT_W-1:0]  ib_count;

  logic [N_OUT-1:0]  ob_wr, ob_rd, ob_full;
  logic [DATA_W-1:0] ob_data [N_OUT];
  logic [N_SIG-1:0]  sg_wr, sg_clr, sg_nz;
  logic [DATA_W-1:0] sg_val [N_SIG];

  logic irq_q, irq_n, irq_en;

  // inbound mailbox
  assign ib_push = host_wr_en && (host_addr == HA_INBOX);
  assign ib_pop  = core_rd_req && (core_rd_sel == RCH_INBOX) && (ib_count != '0);

  msgu_inbox #(.DATA_W(DATA_W), .DEPTH(IN_DEPTH)) u_inbox (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ib_push),
    .push_data (host_wr_data),
    .pop       (ib_pop),
    .head      (ib_head),
    .count     (ib_count),
    .ovf       (inbox_ovf)
  );

  // outbound mailboxes
  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    localparam logic [2:0] MY_ADDR = HA_OUT0 + 3'(g);
    assign ob_wr[g] = core_wr_req && (core_wr_sel == 3'(g)) && !ob_full[g];
    assign ob_rd[g] = host_rd_en && (host_addr == MY_ADDR);
    msgu_outbox #(.DATA_W(DATA_W)) u_outbox (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ob_wr[g]),
      .wr_data (core_wr_data),
      .rd      (ob_rd[g]),
      .full    (ob_full[g]),
      .data    (ob_data[g])
    );
  end

  // signal notification registers
  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    localparam logic [2:0] MY_ADDR = HA_SIG0 + 3'(g);
    localparam logic [2:0] MY_RCH  = RCH_SIG0 + 3'(g);
    assign sg_nz[g]  = (sg_val[g] != '0);
    assign sg_wr[g]  = host_wr_en && (host_addr == MY_ADDR);
    assign sg_clr[g] = core_rd_req && (core_rd_sel == MY_RCH) && sg_nz[g];
    msgu_sig #(.DATA_W(DATA_W)) u_sig (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (sg_wr[g]),
      .wr_data (host_wr_data),
      .or_mode (sig_or_mode[g]),
      .clr     (sg_clr[g]),
      .val     (sg_val[g])
    );
  end

  // core read mux
  always_comb begin
    core_rd_ack  = 1'b0;
    core_rd_data = '0;
    if (core_rd_sel == RCH_INBOX) begin
      core_rd_ack  = ib_pop;
      core_rd_data = ib_head;
    end
    for (int i = 0; i < N_SIG; i++) begin
      if (core_rd_sel == RCH_SIG0 + 3'(i)) begin
        core_rd_ack  = sg_clr[i];
        core_rd_data = sg_val[i];
      end
    end
  end

  assign core_wr_ack = |ob_wr;

  // count mux
  always_comb begin
    core_cnt = '0;
    if (core_cnt_sel == CNT_INBOX) core_cnt = ib_count;
    for (int i = 0; i < N_SIG; i++)
      if (core_cnt_sel == CNT_SIG0 + 3'(i)) core_cnt = CNT_W'(sg_nz[i]);
    for (int i = 0; i < N_OUT; i++)
      if (core_cnt_sel == CNT_OUT0 + 3'(i)) core_cnt = CNT_W'(!ob_full[i]);
  end

  // host read mux
  always_comb begin
    host_rd_data = '0;
    for (int i = 0; i < N_OUT; i++)
      if (ob_rd[i] && ob_full[i]) host_rd_data = ob_data[i];
  end

  // interrupt toward the host
  always_comb begin
    irq_en = ob_wr[IRQ_OUT] || (ob_rd[IRQ_OUT] && ob_full[IRQ_OUT]);
    irq_n  = ob_wr[IRQ_OUT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_n;
  end

  assign host_irq = irq_q;

  a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_req && core_wr_sel == 3'(IRQ_OUT) && core_wr_ack) |=> host_irq);
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !(host_rd_en && host_addr == HA_OUT0 + 3'(IRQ_OUT))) |=> host_irq);
  a_r6_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && host_rd_en && host_addr == HA_OUT0 + 3'(IRQ_OUT)) |=> !host_irq);
  a_r2_one_read_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ib_pop, sg_clr}));
endmodule

// File: tb/msgu_top_tb.sv
module msgu_top_tb;
  localparam int DW = 32;
  localparam int CNT_W = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          core_rd_req, core_wr_req, host_wr_en, host_rd_en;
  logic [2:0]    core_rd_sel, core_wr_sel, core_cnt_sel, host_addr;
  logic [DW-1:0] core_wr_data, host_wr_data, core_rd_data, host_rd_data;
  logic          core_rd_ack, core_wr_ack, host_irq, inbox_ovf;
  logic [CNT_W-1:0] core_cnt;
  logic [1:0]    sig_or_mode;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  msgu_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_rd_req(core_rd_req), .core_rd_sel(core_rd_sel),
    .core_rd_ack(core_rd_ack), .core_rd_data(core_rd_data),
    .core_wr_req(core_wr_req), .core_wr_sel(core_wr_sel),
    .core_wr_data(core_wr_data), .core_wr_ack(core_wr_ack),
    .core_cnt_sel(core_cnt_sel), .core_cnt(core_cnt),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
    .sig_or_mode(sig_or_mode), .host_irq(host_irq), .inbox_ovf(inbox_ovf)
  );

  // op codes: 0 host write, 1 core read, 2 core write, 3 host read, 4 count
  // entry: {op, sel/addr, expect-block, data, expected}
  localparam int NV = 26;
  localparam logic [70:0] VEC [NV] = '{
    {3'd4, 3'd0, 1'b0, 32'h0,  32'h0},   // R2 empty count
    {3'd1, 3'd0, 1'b1, 32'h0,  32'h0},   // R2 read blocks when empty
    {3'd0, 3'd0, 1'b0, 32'h11, 32'h0},
    {3'd0, 3'd0, 1'b0, 32'h22, 32'h0},
    {3'd0, 3'd0, 1'b0, 32'h33, 32'h0},
    {3'd4, 3'd0, 1'b0, 32'h0,  32'h3},   // R2 three waiting
    {3'd1, 3'd0, 1'b0, 32'h0,  32'h11},  // R2 order
    {3'd1, 3'd0, 1'b0, 32'h0,  32'h22},
    {3'd1, 3'd0, 1'b0, 32'h0,  32'h33},
    {3'd1, 3'd0, 1'b1, 32'h0,  32'h0},
    {3'd4, 3'd3, 1'b0, 32'h0,  32'h1},   // R4 free slot
    {3'd2, 3'd0, 1'b0, 32'hA5, 32'h0},   // R4 write accepted
    {3'd4, 3'd3, 1'b0, 32'h0,  32'h0},
    {3'd2, 3'd0, 1'b1, 32'h5A, 32'h0},   // R4 write blocks when full
    {3'd3, 3'd3, 1'b0, 32'h0,  32'hA5},  // R5 host read
    {3'd3, 3'd3, 1'b0, 32'h0,  32'h0},   // R5 empty reads zero
    {3'd4, 3'd3, 1'b0, 32'h0,  32'h1},
    {3'd0, 3'd1, 1'b0, 32'hF0, 32'h0},   // R7 replace mode
    {3'd0, 3'd1, 1'b0, 32'h0F, 32'h0},
    {3'd4, 3'd1, 1'b0, 32'h0,  32'h1},   // R9 nonzero count
    {3'd1, 3'd1, 1'b0, 32'h0,  32'h0F},  // R7 last write wins
    {3'd1, 3'd1, 1'b1, 32'h0,  32'h0},   // R9 cleared, blocks
    {3'd0, 3'd2, 1'b0, 32'hF0, 32'h0},   // R8 OR mode
    {3'd0, 3'd2, 1'b0, 32'h0F, 32'h0},
    {3'd1, 3'd2, 1'b0, 32'h0,  32'hFF},  // R8 merged
    {3'd4, 3'd2, 1'b0, 32'h0,  32'h0}    // R9 cleared
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    core_rd_req = 1'b0; core_wr_req = 1'b0; host_wr_en = 1'b0; host_rd_en = 1'b0;
    core_rd_sel = '0; core_wr_sel = '0; host_addr = '0;
    core_wr_data = '0; host_wr_data = '0;
  endtask

  task automatic finish_cycle();
    @(posedge clk); #1; idle();
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); host_wr_en = 1'b1; host_addr = a; host_wr_data = d;
    finish_cycle();
  endtask

  task automatic cread(input string req, input logic [2:0] s, input logic [DW-1:0] exp);
    @(negedge clk); core_rd_req = 1'b1; core_rd_sel = s; #1;
    check(req, {31'd0, core_rd_ack}, 32'd1);
    check(req, core_rd_data, exp);
    finish_cycle();
  endtask

  task automatic ccount(input string req, input logic [2:0] s, input logic [DW-1:0] exp);
    @(negedge clk); core_cnt_sel = s; #1;
    check(req, DW'(core_cnt), exp);
  endtask

  initial begin
    idle();
    core_cnt_sel = '0;
    sig_or_mode = 2'b10;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 irq", {31'd0, host_irq}, 32'd0);
    check("R1 ovf", {31'd0, inbox_ovf}, 32'd0);
    ccount("R1 inbox count", 3'd0, 0);
    ccount("R1 sig0 count", 3'd1, 0);
    ccount("R1 out0 free", 3'd3, 1);
    ccount("R1 out1 free", 3'd4, 1);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op, sel;
      logic blk;
      logic [DW-1:0] dat, exp;
      {op, sel, blk, dat, exp} = VEC[i];
      @(negedge clk);
      case (op)
        3'd0: begin host_wr_en = 1'b1; host_addr = sel; host_wr_data = dat; end
        3'd1: begin core_rd_req = 1'b1; core_rd_sel = sel; end
        3'd2: begin core_wr_req = 1'b1; core_wr_sel = sel; core_wr_data = dat; end
        3'd3: begin host_rd_en = 1'b1; host_addr = sel; end
        default: core_cnt_sel = sel;
      endcase
      #1;
      case (op)
        3'd1: begin
          check($sformatf("R2/R7/R8/R9 vec%0d ack", i), {31'd0, core_rd_ack}, {31'd0, !blk});
          if (!blk) check($sformatf("R2/R7/R8/R9 vec%0d data", i), core_rd_data, exp);
        end
        3'd2: check($sformatf("R4 vec%0d ack", i), {31'd0, core_wr_ack}, {31'd0, !blk});
        3'd3: check($sformatf("R5 vec%0d data", i), host_rd_data, exp);
        3'd4: check($sformatf("R2/R4/R9 vec%0d count", i), DW'(core_cnt), exp);
        default: ;
      endcase
      finish_cycle();
    end

    // R11: full inbox, push and pop together
    for (int i = 1; i <= 4; i++) hwrite(3'd0, DW'(i));
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = 3'd0; host_wr_data = 32'h5;
    core_rd_req = 1'b1; core_rd_sel = 3'd0; #1;
    check("R11 ack", {31'd0, core_rd_ack}, 32'd1);
    check("R11 oldest", core_rd_data, 32'h1);
    finish_cycle();
    ccount("R11 count stays 4", 3'd0, 4);
    check("R11 no ovf", {31'd0, inbox_ovf}, 32'd0);
    for (int i = 2; i <= 5; i++) cread("R11 drain", 3'd0, DW'(i));

    // R3: overflow replaces newest
    for (int i = 0; i < 4; i++) hwrite(3'd0, 32'hA0 + DW'(i));
    hwrite(3'd0, 32'hEE);
    check("R3 ovf set", {31'd0, inbox_ovf}, 32'd1);
    ccount("R3 count", 3'd0, 4);
    cread("R3 drain", 3'd0, 32'hA0);
    cread("R3 drain", 3'd0, 32'hA1);
    cread("R3 drain", 3'd0, 32'hA2);
    cread("R3 replaced newest", 3'd0, 32'hEE);
    check("R3 ovf sticky", {31'd0, inbox_ovf}, 32'd1);

    // R6 interrupt
    @(negedge clk); core_wr_req = 1'b1; core_wr_sel = 3'd1; core_wr_data = 32'h77; #1;
    check("R6 write ack", {31'd0, core_wr_ack}, 32'd1);
    check("R6 irq low before edge", {31'd0, host_irq}, 32'd0);
    finish_cycle();
    check("R6 irq set", {31'd0, host_irq}, 32'd1);
    ccount("R4 out1 full", 3'd4, 0);
    repeat (3) @(negedge clk);
    check("R6 irq held", {31'd0, host_irq}, 32'd1);
    @(negedge clk); host_rd_en = 1'b1; host_addr = 3'd4; #1;
    check("R5 out1 data", host_rd_data, 32'h77);
    finish_cycle();
    check("R6 irq cleared", {31'd0, host_irq}, 32'd0);
    ccount("R5 out1 empty", 3'd4, 1);

    // R10 collision on signal 0
    hwrite(3'd1, 32'h7);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = 3'd1; host_wr_data = 32'h9;
    core_rd_req = 1'b1; core_rd_sel = 3'd1; #1;
    check("R10 ack", {31'd0, core_rd_ack}, 32'd1);
    check("R10 old value", core_rd_data, 32'h7);
    finish_cycle();
    cread("R10 new value kept", 3'd1, 32'h9);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule